// File: doc/BRIEF.md
# Packed Word Permute Unit

This unit rearranges packed data. A two-bit mode input chooses one of four operations. The first is a 64-bit word shuffle. The second extracts one 16-bit word into a 32-bit scalar. The third inserts a 16-bit value into one word position. The fourth is a 128-bit shuffle that takes 32-bit lanes from two operands. An 8-bit immediate drives each operation. It is split into four 2-bit selector fields, and field k belongs to destination slot k.

The operands are `opa_i` and `opb_i` (128 bits each) and `sc_i` (a 32-bit scalar). The unit produces a 128-bit vector result and a 32-bit scalar result. The datapath is combinational. With the default `REG_OUT = 1`, one output register follows the datapath, so results appear one clock after the inputs. This register has a synchronous, active-high reset.

Top module: `pperm_unit`

## Requirements
- R1: In word-shuffle mode (`mode_i` = 2'b00), destination word k of `res_o[63:0]` (bits 16k+15:16k) is word `imm_i[2k+1:2k]` of `opb_i[63:0]`. For example, a value of 2 in `imm_i[1:0]` places `opb_i[47:32]` into `res_o[15:0]`.
- R2: In extract mode (`mode_i` = 2'b01), `sc_o[15:0]` holds word `imm_i[1:0]` of `opa_i[63:0]`, and `sc_o[31:16]` is zero.
- R3: In insert mode (`mode_i` = 2'b10), `res_o[63:0]` equals `opa_i[63:0]` except at word `imm_i[1:0]`, which takes `sc_i[15:0]`. `sc_i[31:16]` has no effect.
- R4: In extract and insert modes, `imm_i[7:2]` has no effect on either output.
- R5: In lane-shuffle mode (`mode_i` = 2'b11), the 32-bit result lanes are filled as follows:
  - Lanes 0 and 1 are the `opa_i` lanes chosen by `imm_i[1:0]` and `imm_i[3:2]`.
  - Lanes 2 and 3 are the `opb_i` lanes chosen by `imm_i[5:4]` and `imm_i[7:6]`.
  - Lane n occupies bits 32n+31:32n.
- R6: In the three 64-bit modes (word-shuffle, extract, insert), `res_o[127:64]` is zero.
- R7: `sc_o` is zero in every mode except extract. `res_o` is all zero in extract mode.
- R8: With `REG_OUT = 1`, both outputs change only one clock edge after the inputs they follow. While `rst` is high at a rising edge, both outputs clear to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 word shuffle, 01 extract, 10 insert, 11 lane shuffle |
| imm_i | input | 8 | Four 2-bit slot selector fields |
| opa_i | input | 128 | First operand |
| opb_i | input | 128 | Second operand |
| sc_i | input | 32 | Scalar input; low 16 bits used by insert |
| res_o | output | 128 | Vector result |
| sc_o | output | 32 | Scalar result |

## Verification
The bench checks the selector fields in every mode:
- A field read from the wrong bit pair, or applied to the wrong slot, returns a reversed or repeated word order instead of the expected one.
- In lane-shuffle mode, a swapped operand would put `opa_i` lanes in the upper half. The operand upper halves are given distinct values, so such a swap shows.
- Extract and insert are driven with junk in `imm_i[7:2]` and in `sc_i[31:16]`. A design that decodes more immediate bits, or copies more than 16 scalar bits, changes the selected word or corrupts its neighbours.
- The operand upper halves are non-zero, so any leak into `res_o[127:64]` in a 64-bit mode is visible.
- Reset is asserted while a non-trivial operation is driven, so a reset that fails to clear leaves a stale result.

// File: rtl/pperm_pkg.sv
package pperm_pkg;
  localparam int IMM_W   = 8;
  localparam int SLOTS   = 4;
  localparam int SEL_W   = IMM_W / SLOTS;

  typedef enum logic [1:0] {
    PM_WSHUF = 2'b00,
    PM_WEXT  = 2'b01,
    PM_WINS  = 2'b10,
    PM_DSHUF = 2'b11
  } pmode_e;
endpackage

// File: rtl/pperm_sel.sv
// One-of-N lane selector used by every shuffle slot.
module pperm_sel #(
  parameter int W = 16,
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N*W-1:0] src_i,
  input  logic [SW-1:0]  sel_i,
  output logic [W-1:0]   y_o
);
  always_comb begin
    y_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SW'(i)) y_o = src_i[i*W +: W];
    end
  end
endmodule

// File: rtl/pperm_wshuf.sv
// Word shuffle: each destination slot picks any source word.
module pperm_wshuf
  import pperm_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int QW = SLOTS * WORD_W
) (
  input  logic [QW-1:0]    src_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [QW-1:0]    y_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    pperm_sel #(.W(WORD_W), .N(SLOTS)) u_sel (
      .src_i (src_i),
      .sel_i (imm_i[k*SEL_W +: SEL_W]),
      .y_o   (y_o[k*WORD_W +: WORD_W])
    );
  end
endmodule

// File: rtl/pperm_wio.sv
// Single-word extract (zero extended) and insert; only imm[1:0] is decoded.
module pperm_wio
  import pperm_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int QW  = SLOTS * WORD_W,
  localparam int SCW = 2 * WORD_W
) (
  input  logic [QW-1:0]    a_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SCW-1:0]   sc_i,
  output logic [SCW-1:0]   ext_o,
  output logic [QW-1:0]    ins_o
);
  logic [WORD_W-1:0] picked;

  pperm_sel #(.W(WORD_W), .N(SLOTS)) u_pick (
    .src_i (a_i),
    .sel_i (sel_i),
    .y_o   (picked)
  );

  assign ext_o = {{(SCW-WORD_W){1'b0}}, picked};

  for (genvar k = 0; k < SLOTS; k++) begin : g_ins
    assign ins_o[k*WORD_W +: WORD_W] =
      (sel_i == SEL_W'(k)) ? sc_i[WORD_W-1:0] : a_i[k*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/pperm_dshuf.sv
// Lane shuffle: low half of slots from operand A, high half from operand B.
module pperm_dshuf
  import pperm_pkg::*;
#(
  parameter int LANE_W = 32,
  localparam int VW = SLOTS * LANE_W
) (
  input  logic [VW-1:0]    a_i,
  input  logic [VW-1:0]    b_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [VW-1:0]    y_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    if (k < SLOTS / 2) begin : g_from_a
      pperm_sel #(.W(LANE_W), .N(SLOTS)) u_sel (
        .src_i (a_i),
        .sel_i (imm_i[k*SEL_W +: SEL_W]),
        .y_o   (y_o[k*LANE_W +: LANE_W])
      );
    end else begin : g_from_b
      pperm_sel #(.W(LANE_W), .N(SLOTS)) u_sel (
        .src_i (b_i),
        .sel_i (imm_i[k*SEL_W +: SEL_W]),
        .y_o   (y_o[k*LANE_W +: LANE_W])
      );
    end
  end
endmodule

// File: rtl/pperm_unit.sv
module pperm_unit
  import pperm_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int QW  = SLOTS * WORD_W,
  localparam int DW  = 2 * WORD_W,
  localparam int VW  = SLOTS * DW,
  localparam int SCW = 2 * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [VW-1:0]    opa_i,
  input  logic [VW-1:0]    opb_i,
  input  logic [SCW-1:0]   sc_i,
  output logic [VW-1:0]    res_o,
  output logic [SCW-1:0]   sc_o
);
  logic [QW-1:0]  wsh_y, ins_y;
  logic [SCW-1:0] ext_y;
  logic [VW-1:0]  dsh_y;
  logic [VW-1:0]  nxt_res;
  logic [SCW-1:0] nxt_sc;

  pperm_wshuf #(.WORD_W(WORD_W)) u_wshuf (
    .src_i (opb_i[QW-1:0]),
    .imm_i (imm_i),
    .y_o   (wsh_y)
  );

  pperm_wio #(.WORD_W(WORD_W)) u_wio (
    .a_i   (opa_i[QW-1:0]),
    .sel_i (imm_i[SEL_W-1:0]),
    .sc_i  (sc_i),
    .ext_o (ext_y),
    .ins_o (ins_y)
  );

  pperm_dshuf #(.LANE_W(DW)) u_dshuf (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .imm_i (imm_i),
    .y_o   (dsh_y)
  );

  always_comb begin
    nxt_res = '0;
    nxt_sc  = '0;
    case (pmode_e'(mode_i))
      PM_WSHUF: nxt_res[QW-1:0] = wsh_y;
      PM_WEXT:  nxt_sc          = ext_y;
      PM_WINS:  nxt_res[QW-1:0] = ins_y;
      PM_DSHUF: nxt_res         = dsh_y;
      default:  nxt_res         = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_o <= '0;
        sc_o  <= '0;
      end else begin
        res_o <= nxt_res;
        sc_o  <= nxt_sc;
      end
    end

    AST_RST_CLR: assert property (@(posedge clk)
      rst |=> (res_o == '0 && sc_o == '0)); // R8
    AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
      (mode_i != PM_DSHUF) |=> (res_o[VW-1:QW] == '0)); // R6
    AST_EXT_ZEXT: assert property (@(posedge clk) disable iff (rst)
      (mode_i == PM_WEXT) |=> (sc_o[SCW-1:WORD_W] == '0 && res_o == '0)); // R2
    AST_SC_IDLE: assert property (@(posedge clk) disable iff (rst)
      (mode_i != PM_WEXT) |=> (sc_o == '0)); // R7
    AST_INS_KEEP: assert property (@(posedge clk) disable iff (rst)
      (mode_i == PM_WINS && imm_i[SEL_W-1:0] != SEL_W'(SLOTS-1))
      |=> (res_o[QW-1:QW-WORD_W] == $past(opa_i[QW-1:QW-WORD_W]))); // R3
    AST_INS_PUT: assert property (@(posedge clk) disable iff (rst)
      (mode_i == PM_WINS && imm_i[SEL_W-1:0] == '0)
      |=> (res_o[WORD_W-1:0] == $past(sc_i[WORD_W-1:0]))); // R3
    AST_DSH_SRC: assert property (@(posedge clk) disable iff (rst)
      (mode_i == PM_DSHUF && imm_i[IMM_W-1:IMM_W-SEL_W] == '0)
      |=> (res_o[VW-1:VW-DW] == $past(opb_i[DW-1:0]))); // R5
  end else begin : g_comb
    assign res_o = nxt_res;
    assign sc_o  = nxt_sc;
  end
endmodule

// File: tb/tb_pperm_unit.sv
module tb_pperm_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_i = '0;
  logic [7:0]   imm_i = '0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic [31:0]  sc_i = '0;
  logic [127:0] res_o;
  logic [31:0]  sc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pperm_unit dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .imm_i(imm_i),
    .opa_i(opa_i), .opb_i(opb_i), .sc_i(sc_i), .res_o(res_o), .sc_o(sc_o)
  );

  localparam logic [127:0] A0 = 128'h8888_7777_6666_5555_4444_3333_2222_1111;
  localparam logic [127:0] B0 = 128'hFFFF_EEEE_DDDD_CCCC_BBBB_AAAA_9999_8888;

  typedef struct packed {
    logic [1:0]   md;
    logic [7:0]   im;
    logic [127:0] a;
    logic [127:0] b;
    logic [31:0]  s;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'b00, 8'hE4, A0, B0, 32'h0},
    '{2'b00, 8'h55, A0, B0, 32'h0},
    '{2'b00, 8'hB1, B0, A0, 32'h1},
    '{2'b01, 8'h00, A0, B0, 32'h0},
    '{2'b01, 8'hA9, B0, A0, 32'h0},
    '{2'b10, 8'h03, A0, B0, 32'h1234_5678},
    '{2'b10, 8'h5E, B0, A0, 32'hFFFF_0042},
    '{2'b11, 8'h1B, A0, B0, 32'h0},
    '{2'b11, 8'hE4, B0, A0, 32'h0},
    '{2'b11, 8'h00, A0, B0, 32'h0}
  };

  // Reference model written from R1, R2, R3, R5, R6, R7.
  function automatic logic [159:0] model(input vec_t v);
    logic [127:0] r = '0;
    logic [31:0]  s = '0;
    case (v.md)
      2'b00: for (int k = 0; k < 4; k++) r[k*16 +: 16] = v.b[v.im[2*k +: 2]*16 +: 16];
      2'b01: s = {16'h0, v.a[v.im[1:0]*16 +: 16]};
      2'b10: begin
        r[63:0] = v.a[63:0];
        r[v.im[1:0]*16 +: 16] = v.s[15:0];
      end
      default: begin
        r[31:0]   = v.a[v.im[1:0]*32 +: 32];
        r[63:32]  = v.a[v.im[3:2]*32 +: 32];
        r[95:64]  = v.b[v.im[5:4]*32 +: 32];
        r[127:96] = v.b[v.im[7:6]*32 +: 32];
      end
    endcase
    return {s, r};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    mode_i = v.md; imm_i = v.im; opa_i = v.a; opb_i = v.b; sc_i = v.s;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset res", res_o, '0);
    check("R8 reset sc", {96'h0, sc_o}, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [159:0] e;
      apply(VT[i]);
      e = model(VT[i]);
      @(negedge clk);
      check($sformatf("R1/R3/R5/R6 vec%0d res", i), res_o, e[127:0]);
      check($sformatf("R2/R7 vec%0d sc", i), {96'h0, sc_o}, {96'h0, e[159:128]});
    end

    // R1: selector 2 in bits 1:0 copies bits 47:32 into 15:0
    apply('{2'b00, 8'h02, A0, B0, 32'h0});
    @(negedge clk);
    check("R1 field0=2", res_o, {64'h0, 64'h8888_8888_8888_AAAA});
    // R1 reversal, R6 upper zero despite non-zero opa/opb upper
    apply('{2'b00, 8'h1B, A0, B0, 32'h0});
    @(negedge clk);
    check("R1 reverse", res_o, {64'h0, 64'h8888_9999_AAAA_BBBB});
    check("R6 upper zero", {64'h0, res_o[127:64]}, '0);
    // R2/R4: upper immediate bits junk
    apply('{2'b01, 8'hFE, A0, B0, 32'hFFFF_FFFF});
    @(negedge clk);
    check("R2 R4 extract", {96'h0, sc_o}, {96'h0, 32'h0000_3333});
    check("R7 res zero in extract", res_o, '0);
    // R3/R4: insert at word 1, scalar upper junk
    apply('{2'b10, 8'hFD, A0, B0, 32'hDEAD_BEEF});
    @(negedge clk);
    check("R3 R4 insert", res_o, {64'h0, 64'h4444_3333_BEEF_1111});
    check("R7 sc zero in insert", {96'h0, sc_o}, '0);
    // R5: lanes from both operands
    apply('{2'b11, 8'h63, A0, B0, 32'h0});
    @(negedge clk);
    check("R5 lane shuffle", res_o, 128'hBBBBAAAA_DDDDCCCC_22221111_88887777);
    // R8: latency, output holds until the next edge
    @(negedge clk);
    mode_i = 2'b01; imm_i = 8'h03;
    #1;
    check("R8 hold before edge", res_o, 128'hBBBBAAAA_DDDDCCCC_22221111_88887777);
    @(negedge clk);
    check("R8 updated after edge", {96'h0, sc_o}, {96'h0, 32'h0000_4444});
    // R8: reset during activity
    apply('{2'b11, 8'h1B, A0, B0, 32'h0});
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset res", res_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R5 after reset", res_o, model('{2'b11, 8'h1B, A0, B0, 32'h0})[127:0]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule